// File: doc/BRIEF.md
# Low-Power System Clock Controller

This block produces the CPU clock of a small microcontroller from two oscillator tick streams. The main oscillator and the sub oscillator each arrive as single-cycle enable pulses on one fast sampling clock. The block divides the selected stream to make a system clock level and a one-cycle CPU clock enable. Three speed settings are available: main divided by 8, main divided by 2, and sub divided by 2. A speed change is held back until the next rising edge of the system clock, so no phase is ever cut short.

Two low-power requests are supported. A halt request with the oscillators kept alive freezes the system clock high, and any interrupt resumes it in the next cycle. A deep halt request switches both oscillators off and presets a pair of chained wake-up timers. Only an external interrupt restarts the oscillators. The CPU clock then stays off until the chained timers run out, which gives the oscillators time to settle. The timers count the oscillator that was driving the CPU before the deep halt, divided by 16.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset, pstate_o is run, speed_o is 2'b00 (main divided by 8), main_osc_en_o is 1, sub_osc_en_o is 0, sys_clk_o is 1 and sys_ce_o is 0.
- R2: With speed 2'b00, each high phase and each low phase of sys_clk_o lasts 4 main ticks.
- R3: With speed 2'b01, each phase of sys_clk_o lasts 1 main tick.
- R4: With speed 2'b10, each phase of sys_clk_o lasts 1 sub tick, and main ticks have no effect.
- R5: A write of mode_val_i through mode_wr_i is held pending. It becomes active (visible on speed_o) at the next rising edge of sys_clk_o, so the phase in progress keeps its old length. The value 2'b11 is ignored. In run, sys_ce_o is a one-cycle pulse at each rising edge of sys_clk_o.
- R6: sub_wr_i loads sub_val_i into the sub oscillator enable, which shows on sub_osc_en_o in the next cycle outside deep halt.
- R7: A deep halt request in run gives pstate_o = 2'b10 in the next cycle, with both oscillator enables at 0 and sys_clk_o at 1. In that state irq_i has no effect, and ext_irq_i has no effect in run.
- R8: Entering deep halt presets the wake-up timers to 0xFF and 0x01. ext_irq_i then moves the block to stabilizing (pstate_o = 2'b11) with the oscillator enables restored. The block returns to run after exactly 16 x 256 x 2 = 8192 source ticks.
- R9: The wake-up source is the sub oscillator if deep halt was entered in speed 2'b10, and the main oscillator otherwise.
- R10: A halt request in run gives pstate_o = 2'b01 with sys_clk_o at 1 and the oscillator enables unchanged. irq_i or ext_irq_i returns the block to run in the next cycle.
- R11: When the deep halt and halt requests arrive together in run, deep halt wins.
- R12: pstate_o encodes run 2'b00, halt 2'b01, deep halt 2'b10, stabilizing 2'b11. In every state except run, sys_ce_o is 0 and sys_clk_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick_i | input | 1 | Main oscillator tick pulse |
| sub_tick_i | input | 1 | Sub oscillator tick pulse |
| mode_wr_i | input | 1 | Speed setting write strobe |
| mode_val_i | input | 2 | Speed setting: 00 main/8, 01 main/2, 10 sub/2 |
| sub_wr_i | input | 1 | Sub oscillator enable write strobe |
| sub_val_i | input | 1 | Sub oscillator enable value |
| stop_req_i | input | 1 | Deep halt request (oscillators off) |
| wait_req_i | input | 1 | Halt request (oscillators kept) |
| ext_irq_i | input | 1 | External interrupt |
| irq_i | input | 1 | Any other interrupt |
| sys_clk_o | output | 1 | System clock level |
| sys_ce_o | output | 1 | CPU clock enable pulse |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub oscillator enable |
| pstate_o | output | 2 | Power state |
| speed_o | output | 2 | Active speed setting |

## Verification
Two collisions are provoked. The first is a speed write that lands while a low phase is running: the divider is still counting in the old setting when the new value arrives. The scoreboard expects the remaining low phase to keep its old length of 4 and every phase after the rising edge to use the new length. The second collision drives the halt and deep halt requests in the same cycle. The state that follows must be deep halt with both oscillators off, and the wake-up afterwards must take the full chained count.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;

    typedef enum logic [1:0] {
        SPD_MID  = 2'b00,
        SPD_HIGH = 2'b01,
        SPD_LOW  = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_WAIT = 2'b01,
        ST_STOP = 2'b10,
        ST_STAB = 2'b11
    } pstate_e;

endpackage

// File: rtl/lpclk_sysdiv.sv
module lpclk_sysdiv
    import lpclk_pkg::*;
#(
    parameter int MID_DIV  = 8,
    parameter int HIGH_DIV = 2,
    parameter int LOW_DIV  = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_i,
    input  logic   main_tick_i,
    input  logic   sub_tick_i,
    input  speed_e pend_i,
    output speed_e act_o,
    output logic   lvl_o,
    output logic   ce_o
);

    localparam int MID_HALF  = MID_DIV / 2;
    localparam int HIGH_HALF = HIGH_DIV / 2;
    localparam int LOW_HALF  = LOW_DIV / 2;
    localparam int MAX_A     = (MID_HALF > HIGH_HALF) ? MID_HALF : HIGH_HALF;
    localparam int MAX_HALF  = (MAX_A > LOW_HALF) ? MAX_A : LOW_HALF;
    localparam int CNT_W     = $clog2(MAX_HALF) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic             ce;
        speed_e           act;
    } div_t;

    div_t div_d, div_q;
    logic             src_tick;
    logic [CNT_W-1:0] half;

    always_comb begin
        div_d    = div_q;
        div_d.ce = 1'b0;
        src_tick = (div_q.act == SPD_LOW) ? sub_tick_i : main_tick_i;
        case (div_q.act)
            SPD_HIGH: half = CNT_W'(HIGH_HALF);
            SPD_LOW:  half = CNT_W'(LOW_HALF);
            default:  half = CNT_W'(MID_HALF);
        endcase
        if (!run_i) begin
            // clock parked high: new setting may be taken at once
            div_d.cnt = '0;
            div_d.lvl = 1'b1;
            div_d.act = pend_i;
        end else if (src_tick) begin
            if (div_q.cnt == half - 1'b1) begin
                div_d.cnt = '0;
                div_d.lvl = ~div_q.lvl;
                if (!div_q.lvl) begin
                    // rising edge: commit pending speed here only
                    div_d.ce  = 1'b1;
                    div_d.act = pend_i;
                end
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.cnt <= '0;
            div_q.lvl <= 1'b1;
            div_q.ce  <= 1'b0;
            div_q.act <= SPD_MID;
        end else begin
            div_q <= div_d;
        end
    end

    assign act_o = div_q.act;
    assign lvl_o = div_q.lvl;
    assign ce_o  = div_q.ce;

endmodule

// File: rtl/lpclk_waketmr.sv
module lpclk_waketmr #(
    parameter int             PRE_DIV = 16,
    parameter int             TMR_W   = 8,
    parameter logic [TMR_W-1:0] T1_PRE = '1,
    parameter logic [TMR_W-1:0] T2_PRE = TMR_W'(1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic src_sub_i,
    input  logic count_i,
    input  logic main_tick_i,
    input  logic sub_tick_i,
    output logic done_o
);

    localparam int             PW       = $clog2(PRE_DIV);
    localparam logic [PW-1:0]  PRE_LAST = PW'(PRE_DIV - 1);

    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [TMR_W-1:0] t1;
        logic [TMR_W-1:0] t2;
        logic             src_sub;
    } wt_t;

    wt_t  wt_d, wt_q;
    logic tick;
    logic done_c;

    always_comb begin
        wt_d   = wt_q;
        done_c = 1'b0;
        tick   = wt_q.src_sub ? sub_tick_i : main_tick_i;
        if (load_i) begin
            wt_d.pre     = '0;
            wt_d.t1      = T1_PRE;
            wt_d.t2      = T2_PRE;
            wt_d.src_sub = src_sub_i;
        end else if (count_i && tick) begin
            if (wt_q.pre == PRE_LAST) begin
                wt_d.pre = '0;
                if (wt_q.t1 == '0) begin
                    // first stage underflow clocks second stage
                    wt_d.t1 = T1_PRE;
                    if (wt_q.t2 == '0) begin
                        done_c  = 1'b1;
                        wt_d.t2 = T2_PRE;
                    end else begin
                        wt_d.t2 = wt_q.t2 - 1'b1;
                    end
                end else begin
                    wt_d.t1 = wt_q.t1 - 1'b1;
                end
            end else begin
                wt_d.pre = wt_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wt_q.pre     <= '0;
            wt_q.t1      <= T1_PRE;
            wt_q.t2      <= T2_PRE;
            wt_q.src_sub <= 1'b0;
        end else begin
            wt_q <= wt_d;
        end
    end

    assign done_o = done_c;

endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
    import lpclk_pkg::*;
#(
    parameter int MID_DIV  = 8,
    parameter int HIGH_DIV = 2,
    parameter int LOW_DIV  = 2,
    parameter int PRE_DIV  = 16,
    parameter int TMR_W    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_tick_i,
    input  logic       sub_tick_i,
    input  logic       mode_wr_i,
    input  logic [1:0] mode_val_i,
    input  logic       sub_wr_i,
    input  logic       sub_val_i,
    input  logic       stop_req_i,
    input  logic       wait_req_i,
    input  logic       ext_irq_i,
    input  logic       irq_i,
    output logic       sys_clk_o,
    output logic       sys_ce_o,
    output logic       main_osc_en_o,
    output logic       sub_osc_en_o,
    output logic [1:0] pstate_o,
    output logic [1:0] speed_o
);

    typedef struct packed {
        pstate_e st;
        speed_e  pend;
        logic    sub_on;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    logic   load_c;
    logic   wake_done;
    logic   main_en, sub_en;
    logic   main_live, sub_live;
    logic   run_next;
    speed_e act_spd;
    logic   div_lvl, div_ce;

    always_comb begin
        ctl_d  = ctl_q;
        load_c = 1'b0;
        if (mode_wr_i && (mode_val_i != SPD_RSVD)) begin
            ctl_d.pend = speed_e'(mode_val_i);
        end
        if (sub_wr_i) begin
            ctl_d.sub_on = sub_val_i;
        end
        case (ctl_q.st)
            ST_RUN: begin
                if (stop_req_i) begin
                    ctl_d.st = ST_STOP;
                    load_c   = 1'b1;
                end else if (wait_req_i) begin
                    ctl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: if (irq_i || ext_irq_i) ctl_d.st = ST_RUN;
            ST_STOP: if (ext_irq_i)          ctl_d.st = ST_STAB;
            default: if (wake_done)          ctl_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_RUN;
            ctl_q.pend   <= SPD_MID;
            ctl_q.sub_on <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign main_en   = (ctl_q.st != ST_STOP);
    assign sub_en    = ctl_q.sub_on && (ctl_q.st != ST_STOP);
    assign main_live = main_tick_i && main_en;
    assign sub_live  = sub_tick_i && sub_en;
    assign run_next  = (ctl_d.st == ST_RUN);

    lpclk_sysdiv #(
        .MID_DIV  (MID_DIV),
        .HIGH_DIV (HIGH_DIV),
        .LOW_DIV  (LOW_DIV)
    ) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run_next),
        .main_tick_i (main_live),
        .sub_tick_i  (sub_live),
        .pend_i      (ctl_q.pend),
        .act_o       (act_spd),
        .lvl_o       (div_lvl),
        .ce_o        (div_ce)
    );

    lpclk_waketmr #(
        .PRE_DIV (PRE_DIV),
        .TMR_W   (TMR_W)
    ) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_c),
        .src_sub_i   (act_spd == SPD_LOW),
        .count_i     (ctl_q.st == ST_STAB),
        .main_tick_i (main_live),
        .sub_tick_i  (sub_live),
        .done_o      (wake_done)
    );

    assign sys_clk_o     = div_lvl;
    assign sys_ce_o      = div_ce;
    assign main_osc_en_o = main_en;
    assign sub_osc_en_o  = sub_en;
    assign pstate_o      = ctl_q.st;
    assign speed_o       = act_spd;

endmodule

// File: rtl/lpclk_ctrl_chk.sv
module lpclk_ctrl_chk
    import lpclk_pkg::*;
#(
    parameter int WAKE_TICKS = 16 * 256 * 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_clk,
    input logic       sys_ce,
    input logic       main_en,
    input logic       sub_en,
    input logic [1:0] pstate,
    input logic [1:0] speed,
    input logic       main_tick,
    input logic       sub_tick,
    input logic       irq,
    input logic       ext_irq,
    input logic       stop_req,
    input logic       wait_req
);

    int   stab_cnt;
    logic src_sub;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stab_cnt <= 0;
            src_sub  <= 1'b0;
        end else begin
            if (pstate == ST_RUN && stop_req) src_sub <= (speed == SPD_LOW);
            if (pstate == ST_STAB) begin
                if (src_sub ? (sub_tick && sub_en) : main_tick) stab_cnt <= stab_cnt + 1;
            end else begin
                stab_cnt <= 0;
            end
        end
    end

    p_ce_only_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ce |-> (pstate == ST_RUN));
    p_park_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate != ST_RUN) |-> sys_clk);
    p_stop_osc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_STOP) |-> (!main_en && !sub_en));
    p_stop_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_RUN && stop_req) |=> (pstate == ST_STOP));
    p_wait_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_RUN && wait_req && !stop_req) |=> (pstate == ST_WAIT));
    p_wait_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_WAIT && (irq || ext_irq)) |=> (pstate == ST_RUN));
    p_wait_main_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_WAIT) |-> main_en);
    p_stab_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_STAB && $past(pstate) != ST_STAB) |-> ($past(pstate) == ST_STOP));
    p_wake_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == ST_RUN && $past(pstate) == ST_STAB) |-> (stab_cnt == WAKE_TICKS));
    p_ce_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ce |-> (sys_clk && !$past(sys_clk)));
    p_speed_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(speed) && pstate == ST_RUN && $past(pstate) == ST_RUN) |-> sys_ce);

endmodule

bind lpclk_ctrl lpclk_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_clk   (sys_clk_o),
    .sys_ce    (sys_ce_o),
    .main_en   (main_osc_en_o),
    .sub_en    (sub_osc_en_o),
    .pstate    (pstate_o),
    .speed     (speed_o),
    .main_tick (main_tick_i),
    .sub_tick  (sub_tick_i),
    .irq       (irq_i),
    .ext_irq   (ext_irq_i),
    .stop_req  (stop_req_i),
    .wait_req  (wait_req_i)
);

// File: tb/lpclk_ctrl_tb.sv
module lpclk_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_tick = 1'b0;
    logic       sub_tick = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_val = 2'b00;
    logic       sub_wr = 1'b0;
    logic       sub_val = 1'b0;
    logic       stop_req = 1'b0;
    logic       wait_req = 1'b0;
    logic       ext_irq = 1'b0;
    logic       irq = 1'b0;
    logic       sys_clk, sys_ce, main_en, sub_en;
    logic [1:0] pstate, speed;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    int    exp_q[$];
    string sb_tag = "R2";
    int    plen = 0;
    logic  prev_lvl = 1'b1;
    int    stab_main = 0;
    int    stab_sub = 0;
    int    nonrun_bad = 0;
    logic  main_gate = 1'b0;
    int    sub_ph = 0;

    localparam int WAKE_EXP = 16 * (8'hFF + 1) * (8'h01 + 1);

    always #10 clk = ~clk;

    lpclk_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .main_tick_i   (main_tick),
        .sub_tick_i    (sub_tick),
        .mode_wr_i     (mode_wr),
        .mode_val_i    (mode_val),
        .sub_wr_i      (sub_wr),
        .sub_val_i     (sub_val),
        .stop_req_i    (stop_req),
        .wait_req_i    (wait_req),
        .ext_irq_i     (ext_irq),
        .irq_i         (irq),
        .sys_clk_o     (sys_clk),
        .sys_ce_o      (sys_ce),
        .main_osc_en_o (main_en),
        .sub_osc_en_o  (sub_en),
        .pstate_o      (pstate),
        .speed_o       (speed)
    );

    // oscillator models: main every cycle, sub every fourth cycle
    always @(posedge clk) begin
        #1;
        main_tick = main_gate;
        sub_tick  = main_gate && (sub_ph == 3);
        sub_ph    = (sub_ph + 1) % 4;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: phase lengths against the scoreboard, plus state bookkeeping
    always @(negedge clk) begin
        if (pstate == 2'b00) begin
            if (sys_clk != prev_lvl) begin
                if (exp_q.size() > 0) chk(sb_tag, plen, exp_q.pop_front());
                plen = 1;
            end else begin
                plen++;
            end
        end else begin
            plen = 0;
            if (sys_ce || !sys_clk) nonrun_bad++;
        end
        prev_lvl = sys_clk;
        if (pstate == 2'b11) begin
            if (main_tick) stab_main++;
            if (sub_tick && sub_en) stab_sub++;
        end
    end

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_ce();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!sys_ce && g < 1000);
    endtask

    task automatic drain(input string tag);
        int g = 0;
        while (exp_q.size() > 0 && g < 2000) begin
            @(negedge clk);
            g++;
        end
        if (exp_q.size() > 0) begin
            chk(tag, exp_q.size(), 0);
            exp_q.delete();
        end
    endtask

    task automatic expect_phases(input string tag, input int n, input int len_e);
        wait_ce();
        wait_ce();
        edge1();
        sb_tag = tag;
        for (int i = 0; i < n; i++) exp_q.push_back(len_e);
        drain(tag);
    endtask

    task automatic write_mode(input logic [1:0] v);
        edge1();
        mode_wr  = 1'b1;
        mode_val = v;
        edge1();
        mode_wr  = 1'b0;
    endtask

    task automatic pulse_stop();
        edge1();
        stop_req = 1'b1;
        edge1();
        stop_req = 1'b0;
    endtask

    task automatic pulse_ext();
        edge1();
        ext_irq = 1'b1;
        edge1();
        ext_irq = 1'b0;
    endtask

    task automatic pulse_irq();
        edge1();
        irq = 1'b1;
        edge1();
        irq = 1'b0;
    endtask

    task automatic wait_run(input int limit);
        int g = 0;
        while (pstate != 2'b00 && g < limit) begin
            @(negedge clk);
            g++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pstate", pstate, 0);
        chk("R1 speed", speed, 0);
        chk("R1 main_en", main_en, 1);
        chk("R1 sub_en", sub_en, 0);
        chk("R1 sys_clk", sys_clk, 1);
        chk("R1 sys_ce", sys_ce, 0);
        main_gate = 1'b1;

        // R2 divide by 8
        expect_phases("R2", 6, 4);

        // R5 write lands during a low phase: old low length kept, then new
        wait_ce();
        do @(negedge clk); while (sys_clk);
        edge1();
        sb_tag = "R5";
        exp_q.push_back(4);
        for (int i = 0; i < 4; i++) exp_q.push_back(1);
        mode_wr  = 1'b1;
        mode_val = 2'b01;
        edge1();
        mode_wr  = 1'b0;
        drain("R5");
        chk("R5 speed", speed, 1);

        // R3 divide by 2
        expect_phases("R3", 6, 1);

        // R5 reserved code ignored
        write_mode(2'b11);
        expect_phases("R5 rsvd", 4, 1);
        chk("R5 rsvd speed", speed, 1);

        // R6 sub oscillator enable
        edge1();
        sub_wr  = 1'b1;
        sub_val = 1'b1;
        edge1();
        sub_wr  = 1'b0;
        @(negedge clk);
        chk("R6 sub_en", sub_en, 1);

        // R4 sub divided by 2
        write_mode(2'b10);
        expect_phases("R4", 6, 4);
        chk("R4 speed", speed, 2);

        write_mode(2'b00);
        expect_phases("R2 back", 4, 4);

        write_mode(2'b01);
        wait_ce();
        wait_ce();

        // R7 ext_irq in run ignored
        pulse_ext();
        @(negedge clk);
        chk("R7 ext in run", pstate, 0);

        // R7 deep halt entry
        pulse_stop();
        @(negedge clk);
        chk("R7 pstate", pstate, 2);
        chk("R7 main_en", main_en, 0);
        chk("R7 sub_en", sub_en, 0);
        chk("R7 sys_clk", sys_clk, 1);
        pulse_irq();
        repeat (5) @(negedge clk);
        chk("R7 irq ignored", pstate, 2);

        // R8 wake-up from main source
        stab_main = 0;
        stab_sub  = 0;
        pulse_ext();
        @(negedge clk);
        chk("R8 pstate", pstate, 3);
        chk("R8 main_en", main_en, 1);
        chk("R8 sub_en", sub_en, 1);
        chk("R8 sys_ce", sys_ce, 0);
        wait_run(40000);
        chk("R8 run", pstate, 0);
        chk("R8 ticks", stab_main, WAKE_EXP);
        expect_phases("R8 resume", 4, 1);

        // R9 wake-up from sub source after low-speed deep halt
        write_mode(2'b10);
        wait_ce();
        wait_ce();
        pulse_stop();
        @(negedge clk);
        chk("R9 pstate", pstate, 2);
        stab_main = 0;
        stab_sub  = 0;
        pulse_ext();
        wait_run(40000);
        chk("R9 run", pstate, 0);
        chk("R9 sub ticks", stab_sub, WAKE_EXP);
        expect_phases("R9 resume", 4, 4);

        // R10 halt with oscillators kept, resumed by irq
        edge1();
        wait_req = 1'b1;
        edge1();
        wait_req = 1'b0;
        @(negedge clk);
        chk("R10 pstate", pstate, 1);
        chk("R10 main_en", main_en, 1);
        chk("R10 sub_en", sub_en, 1);
        repeat (20) @(negedge clk);
        chk("R10 held", pstate, 1);
        chk("R10 sys_clk", sys_clk, 1);
        pulse_irq();
        @(negedge clk);
        chk("R10 irq resume", pstate, 0);

        // R10 resumed by external interrupt
        edge1();
        wait_req = 1'b1;
        edge1();
        wait_req = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 pstate 2", pstate, 1);
        pulse_ext();
        @(negedge clk);
        chk("R10 ext resume", pstate, 0);

        // R11 both requests together
        write_mode(2'b01);
        wait_ce();
        wait_ce();
        edge1();
        stop_req = 1'b1;
        wait_req = 1'b1;
        edge1();
        stop_req = 1'b0;
        wait_req = 1'b0;
        @(negedge clk);
        chk("R11 pstate", pstate, 2);
        chk("R11 main_en", main_en, 0);
        stab_main = 0;
        pulse_ext();
        wait_run(40000);
        chk("R11 ticks", stab_main, WAKE_EXP);
        expect_phases("R11 resume", 4, 1);

        // R12 no enable pulse and no low level outside run
        chk("R12 nonrun", nonrun_bad, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule